// File: doc/BRIEF.md
# ADC Power-State and Sample-Qualification Controller

This block sits on the host side of an 18-bit successive-approximation converter with a serial output. It drives the converter's power-down line and follows the converter through its power states: running, entering full power-down, powered down, two wake-up phases, and nap. After a wake from full power-down it discards the first two conversions. It then waits a settling interval before it calls any result accurate. Every captured word comes out tagged with a valid bit that reflects the power state at the moment of capture.

The bit-level serial shifter is outside the block and hands over finished words with a one-cycle strobe. The controller turns each word into two's complement, whichever coding the converter was set to produce. It also sequences host read requests so that no read starts while a conversion is in progress or within a guard interval after BUSY falls, since that is when the converter refreshes its output register. A request that arrives in the guard is held and issued once the guard has ended.

All intervals are counted in system clock cycles. The defaults are derived from the clock frequency parameter: 10 µs for power-down entry, 200 ns for nap wake and 4 ms for settling.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset, state_o is RUN (code 0), pd_out, sdo_hiz, rd_go and smp_valid are low.
- R2: A high pd_req in RUN, NAP, WAKE_DROP or WAKE_SETTLE moves the block to PD_ENTRY (code 1) at the next edge and raises pd_out. PD_ENTRY lasts exactly PD_CYC cycles and then becomes OFF (code 2). sdo_hiz is high only in OFF, and pd_out is high in PD_ENTRY and OFF.
- R3: In OFF, a low pd_req moves the block to WAKE_DROP (code 3) at the next edge, with pd_out and sdo_hiz low.
- R4: In WAKE_DROP the first BUSY falling edge leaves the state unchanged. The second moves it to WAKE_SETTLE (code 4).
- R5: WAKE_SETTLE lasts exactly SETTLE_CYC cycles and then becomes RUN.
- R6: In RUN, a BUSY falling edge with conv_qual low moves the block to NAP (code 5). With conv_qual high the block stays in RUN.
- R7: In NAP, a conv_start pulse starts a wake. The state stays NAP for NAP_CYC further cycles after the edge that sees conv_start, and is RUN on the edge after that.
- R8: One cycle after cap_stb, smp_valid is high for one cycle. smp_ok is high if and only if the state at the capturing edge was RUN or NAP.
- R9: smp_data equals cap_word with bit 17 inverted when fmt_binary is 1, and equals cap_word unchanged when fmt_binary is 0.
- R10: A read request made while busy is high, or within GUARD_CYC cycles after the edge that sees BUSY fall, is held. rd_go pulses once, GUARD_CYC+1 edges after the falling edge. Repeated requests while held merge into that single pulse.
- R11: A read request outside the guard produces a one-cycle rd_go pulse at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Host request for full power-down |
| conv_qual | input | 1 | Conversion-start qualifier; low at end of conversion selects nap |
| conv_start | input | 1 | Sample-start command pulse |
| busy | input | 1 | Converter BUSY line |
| fmt_binary | input | 1 | 1 when the converter emits straight binary |
| cap_stb | input | 1 | Shifter strobe: cap_word holds a complete result |
| cap_word | input | 18 | Word captured by the shifter |
| rd_req | input | 1 | Host read request pulse |
| state_o | output | 3 | Power state code |
| pd_out | output | 1 | Power-down line to the converter |
| sdo_hiz | output | 1 | Converter data output is tri-stated |
| rd_go | output | 1 | Read may start now (one-cycle pulse) |
| smp_valid | output | 1 | Normalised sample present |
| smp_data | output | 18 | Sample in two's complement |
| smp_ok | output | 1 | Sample meets specified accuracy |

## Verification
The bench drives all inputs just after a rising edge and samples the outputs at the same point, so every result is read after the edge that produced it. Sample outputs and the state change after a pd_req change, a BUSY fall or a release from OFF are due one edge after the stimulus. PD_ENTRY ends after PD_CYC further edges, WAKE_SETTLE after SETTLE_CYC and a nap wake after NAP_CYC. A held read issues GUARD_CYC+1 edges after the falling edge. The bench counts its steps to each of these points and also checks the cycle just before, so that a result that arrives one cycle early or late is reported.

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl #(
  parameter int DATA_W     = 18,
  parameter int CLK_KHZ    = 50000,
  parameter int PD_CYC     = CLK_KHZ / 100,
  parameter int NAP_CYC    = (CLK_KHZ + 4999) / 5000,
  parameter int SETTLE_CYC = CLK_KHZ * 4,
  parameter int GUARD_CYC  = (CLK_KHZ + 9999) / 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req,
  input  logic              conv_qual,
  input  logic              conv_start,
  input  logic              busy,
  input  logic              fmt_binary,
  input  logic              cap_stb,
  input  logic [DATA_W-1:0] cap_word,
  input  logic              rd_req,
  output logic [2:0]        state_o,
  output logic              pd_out,
  output logic              sdo_hiz,
  output logic              rd_go,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_ok
);
  localparam int MAXA = (PD_CYC > NAP_CYC) ? PD_CYC : NAP_CYC;
  localparam int MAXC = (MAXA > SETTLE_CYC) ? MAXA : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int GW   = $clog2(GUARD_CYC + 1);

  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_PD_ENTRY    = 3'd1,
    ST_OFF         = 3'd2,
    ST_WAKE_DROP   = 3'd3,
    ST_WAKE_SETTLE = 3'd4,
    ST_NAP         = 3'd5
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic          busy_q, drop_one, waking, rd_pend;

  wire busy_fall = busy_q & ~busy;
  wire guard     = busy | busy_fall | (gcnt != '0);
  wire rd_want   = rd_pend | rd_req;

  assign state_o = st;
  assign pd_out  = (st == ST_PD_ENTRY) || (st == ST_OFF);
  assign sdo_hiz = (st == ST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      gcnt      <= '0;
      rd_pend   <= 1'b0;
      rd_go     <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_ok    <= 1'b0;
    end else begin
      busy_q    <= busy;
      if (busy_fall)          gcnt <= GW'(GUARD_CYC);
      else if (gcnt != '0)    gcnt <= gcnt - 1'b1;
      rd_go     <= rd_want & ~guard;
      rd_pend   <= rd_want & guard;
      smp_valid <= cap_stb;
      if (cap_stb) begin
        smp_data <= fmt_binary ? {~cap_word[DATA_W-1], cap_word[DATA_W-2:0]} : cap_word;
        smp_ok   <= (st == ST_RUN) || (st == ST_NAP);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      cnt      <= '0;
      drop_one <= 1'b0;
      waking   <= 1'b0;
    end else begin
      case (st)
        ST_RUN: begin
          if (pd_req) begin
            st  <= ST_PD_ENTRY;
            cnt <= '0;
          end else if (busy_fall && !conv_qual) begin
            st     <= ST_NAP;
            waking <= 1'b0;
          end
        end
        ST_PD_ENTRY: begin
          if (cnt == CW'(PD_CYC - 1)) st <= ST_OFF;
          else                        cnt <= cnt + 1'b1;
        end
        ST_OFF: begin
          if (!pd_req) begin
            st       <= ST_WAKE_DROP;
            drop_one <= 1'b0;
          end
        end
        ST_WAKE_DROP: begin
          if (pd_req) begin
            st  <= ST_PD_ENTRY;
            cnt <= '0;
          end else if (busy_fall) begin
            if (drop_one) begin
              st  <= ST_WAKE_SETTLE;
              cnt <= '0;
            end else begin
              drop_one <= 1'b1;
            end
          end
        end
        ST_WAKE_SETTLE: begin
          if (pd_req) begin
            st  <= ST_PD_ENTRY;
            cnt <= '0;
          end else if (cnt == CW'(SETTLE_CYC - 1)) begin
            st <= ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_NAP: begin
          if (pd_req) begin
            st  <= ST_PD_ENTRY;
            cnt <= '0;
          end else if (waking) begin
            if (cnt == CW'(NAP_CYC - 1)) st <= ST_RUN;
            else                         cnt <= cnt + 1'b1;
          end else if (conv_start) begin
            waking <= 1'b1;
            cnt    <= '0;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cap_stb,
  input logic [2:0] state_o,
  input logic       pd_out,
  input logic       sdo_hiz,
  input logic       rd_go,
  input logic       smp_valid,
  input logic       smp_ok
);
  AST_OFF_FROM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |-> $past(state_o) == 3'd1); // R2
  AST_HIZ_NEEDS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_hiz |-> pd_out); // R2
  AST_RELEASE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd2 && state_o == 3'd3) |-> (!pd_out && !sdo_hiz)); // R3
  AST_SETTLE_FROM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> $past(state_o) == 3'd3); // R4
  AST_NAP_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && $past(state_o) != 3'd5) |-> $past(state_o) == 3'd0); // R6
  AST_CAP_GIVES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> smp_valid); // R8
  AST_OK_ONLY_ACCURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ok) |-> ($past(state_o) == 3'd0 || $past(state_o) == 3'd5)); // R8
  AST_NO_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_go); // R10
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cap_stb(cap_stb),
  .state_o(state_o), .pd_out(pd_out), .sdo_hiz(sdo_hiz), .rd_go(rd_go),
  .smp_valid(smp_valid), .smp_ok(smp_ok)
);

// File: tb/tb_adc_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_adc_pwr_ctrl;
  localparam int PD  = 8;
  localparam int NAP = 3;
  localparam int SET = 20;
  localparam int GRD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_req = 0, conv_qual = 1, conv_start = 0, busy = 0, fmt_binary = 0;
  logic cap_stb = 0, rd_req = 0;
  logic [17:0] cap_word = '0;
  logic [2:0]  state_o;
  logic pd_out, sdo_hiz, rd_go, smp_valid, smp_ok;
  logic [17:0] smp_data;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_pwr_ctrl #(.PD_CYC(PD), .NAP_CYC(NAP), .SETTLE_CYC(SET), .GUARD_CYC(GRD)) dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .conv_qual(conv_qual),
    .conv_start(conv_start), .busy(busy), .fmt_binary(fmt_binary),
    .cap_stb(cap_stb), .cap_word(cap_word), .rd_req(rd_req),
    .state_o(state_o), .pd_out(pd_out), .sdo_hiz(sdo_hiz), .rd_go(rd_go),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ok(smp_ok));

  function automatic logic [17:0] to_twos(input logic [17:0] w, input logic bin);
    return bin ? (w ^ 18'h20000) : w;
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic capture(input logic [17:0] w, input logic bin, input logic exp_ok, input string req);
    cap_word = w; fmt_binary = bin; cap_stb = 1; step(); cap_stb = 0;
    chk({req, " smp_valid"}, smp_valid, 1);
    chk({req, " smp_ok"}, smp_ok, exp_ok);
    step();
    chk({req, " smp_valid drop"}, smp_valid, 0);
  endtask

  task automatic busy_pulse();
    busy = 1; step(); busy = 0; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) step();
    chk("R1 state", state_o, 0); chk("R1 pd_out", pd_out, 0);
    chk("R1 sdo_hiz", sdo_hiz, 0); chk("R1 rd_go", rd_go, 0);
    chk("R1 smp_valid", smp_valid, 0);
    rst_n = 1; step();
    chk("R1 state after release", state_o, 0);

    // R9 directed corners
    capture(18'h00000, 1, 1, "R9 zero bin");   chk("R9 zero", smp_data, 18'h20000);
    capture(18'h3FFFF, 1, 1, "R9 full bin");   chk("R9 full", smp_data, 18'h1FFFF);
    capture(18'h20000, 1, 1, "R9 mid bin");    chk("R9 mid", smp_data, 18'h00000);
    capture(18'h1FFFF, 0, 1, "R9 twos pass");  chk("R9 pass", smp_data, 18'h1FFFF);
    for (int i = 0; i < 40; i++) begin
      logic [17:0] w;
      logic b;
      w = 18'($urandom); b = 1'($urandom);
      cap_word = w; fmt_binary = b; cap_stb = 1; step(); cap_stb = 0;
      chk("R9 random data", smp_data, to_twos(w, b));
      chk("R8 random ok in RUN", smp_ok, 1);
    end

    // R11 read outside guard
    rd_req = 1; step(); rd_req = 0;
    chk("R11 rd_go issued", rd_go, 1);
    step(); chk("R11 rd_go one cycle", rd_go, 0);

    // R10 deferral, merged requests
    conv_qual = 1; busy = 1; step();
    rd_req = 1; step(); rd_req = 0;
    chk("R10 held during busy", rd_go, 0);
    step(); rd_req = 1; step(); rd_req = 0;
    chk("R10 held second request", rd_go, 0);
    busy = 0;
    for (int k = 1; k <= GRD + 1; k++) begin
      step(); chk("R10 held in guard", rd_go, 0);
    end
    step(); chk("R10 deferred read issued", rd_go, 1);
    step(); chk("R10 single pulse", rd_go, 0);
    chk("R6 qual high stays RUN", state_o, 0);

    // random guard trials
    for (int t = 0; t < 6; t++) begin
      int len;
      len = 1 + int'($urandom % 5);
      busy = 1;
      for (int j = 0; j < len; j++) begin
        rd_req = 1'($urandom); step(); rd_req = 0;
        chk("R10 random busy blocks read", rd_go, 0);
      end
      rd_req = 1; busy = 0; step(); rd_req = 0;
      for (int k = 2; k <= GRD + 1; k++) begin
        step(); chk("R10 random guard", rd_go, 0);
      end
      step(); chk("R10 random issue", rd_go, 1);
      step();
    end

    // R6 nap entry, R8 in nap, R7 wake
    conv_qual = 0; busy_pulse();
    chk("R6 nap entry", state_o, 5);
    conv_qual = 1;
    capture(18'h12345, 0, 1, "R8 nap ok");
    conv_start = 1; step(); conv_start = 0;
    chk("R7 nap at start edge", state_o, 5);
    for (int k = 2; k <= NAP; k++) step();
    chk("R7 still nap last cycle", state_o, 5);
    step(); chk("R7 back to RUN", state_o, 0);

    // R2 power-down entry
    pd_req = 1; step();
    chk("R2 entry state", state_o, 1); chk("R2 pd_out", pd_out, 1);
    chk("R2 no hiz in entry", sdo_hiz, 0);
    for (int k = 2; k <= PD; k++) step();
    chk("R2 entry last cycle", state_o, 1);
    step(); chk("R2 off", state_o, 2); chk("R2 hiz in off", sdo_hiz, 1);
    capture(18'h00001, 0, 0, "R8 off not ok");

    // R3 release
    pd_req = 0; step();
    chk("R3 wake_drop", state_o, 3); chk("R3 pd_out low", pd_out, 0);
    chk("R3 hiz low", sdo_hiz, 0);
    capture(18'h00002, 0, 0, "R8 drop not ok");
    busy_pulse(); chk("R4 first fall stays", state_o, 3);
    busy_pulse(); chk("R4 second fall settle", state_o, 4);
    capture(18'h00003, 0, 0, "R8 settle not ok");
    for (int k = 4; k <= SET; k++) step();
    chk("R5 settle last cycle", state_o, 4);
    step(); chk("R5 run after settle", state_o, 0);
    capture(18'h00004, 0, 1, "R8 run ok after wake");

    // R2 from nap and from wake_drop
    conv_qual = 0; busy_pulse(); conv_qual = 1;
    chk("R6 nap again", state_o, 5);
    pd_req = 1; step(); chk("R2 entry from nap", state_o, 1);
    for (int k = 1; k <= PD; k++) step();
    chk("R2 off again", state_o, 2);
    pd_req = 0; step(); chk("R3 drop again", state_o, 3);
    pd_req = 1; step(); chk("R2 entry from drop", state_o, 1);
    chk("R2 pd_out from drop", pd_out, 1);
    pd_req = 0;
    repeat (3) step();
    finish_run();
  end
endmodule